// File: doc/BRIEF.md
# Unified Forward/Inverse NTT Butterfly with Redundant Residues

This block is one butterfly for a number theoretic transform engine. A single fixed-latency pipeline serves both directions. The direction is chosen by a mode bit that is sampled with each operand pair. In forward mode it forms the decimation-in-time pair a + b·ω and a − b·ω. In inverse mode it forms the decimation-in-frequency pair (a + b)/2 and (a − b)·ω/2. A memory and address sequencer around it supplies the coefficient pairs and the twiddles, and writes the results back.

Every coefficient that enters or leaves the block is held in the redundant range [0, 2Q−1]. Internal values may reach 4Q, and the internal words are two bits wider than the modulus for that reason. The Montgomery product needs no trailing correction, and neither does the inverse-mode difference that feeds it. Both inverse halvings are absorbed into the datapath. One comes from twiddles that the caller has already scaled by 2⁻¹ mod Q. The other is folded into the range fix-up of the sum. The modulus width W (17 by default) and the modulus Q are build parameters. The Montgomery radix is R = 2^(W+4).

Top module: `ntt_bfly_unified`

## Requirements
- R1: With inInverse=0, the results satisfy outX ≡ a + b·ω and outY ≡ a − b·ω (mod Q). Here ω = inTwiddle·R⁻¹ mod Q and R = 2^(W+4).
- R2: With inInverse=1, the results satisfy outX ≡ (a + b)·2⁻¹ and outY ≡ (a − b)·ω (mod Q), with ω as in R1. The caller supplies a twiddle that already carries the factor 2⁻¹.
- R3: When a, b and the twiddle all lie in [0, 2Q−1], both outputs also lie in [0, 2Q−1].
- R4: outValid is high exactly 8 cycles after a cycle with inValid high, and low 8 cycles after a cycle with inValid low.
- R5: A new operand pair is accepted every cycle. The mode may differ from one cycle to the next, and each result follows the mode it entered with.
- R6: While rstN is low, outValid is low. Operands in flight when reset is asserted never appear at the output.
- R7: In inverse mode outX is exact, not only correct mod Q. Let s = a + b, minus 2Q if s ≥ 2Q. Then outX = s/2 when s is even and (s + Q)/2 when s is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair present this cycle |
| inInverse | input | 1 | 0 = forward butterfly, 1 = inverse butterfly |
| inA | input | W+1 | First coefficient, in [0, 2Q−1] |
| inB | input | W+1 | Second coefficient, in [0, 2Q−1] |
| inTwiddle | input | W+1 | Twiddle in Montgomery form, in [0, 2Q−1] |
| outValid | output | 1 | Result pair present this cycle |
| outX | output | W+1 | First result coefficient |
| outY | output | W+1 | Second result coefficient |

## Verification
The bench builds the block with W=5 and Q=17, so each operand takes 34 redundant values and the Montgomery radix is 512. At that size every combination of a, b and twiddle can be swept in both modes, 78,608 pairs in all. The mode alternates every cycle, and an idle cycle is inserted now and then. The sweep therefore reaches the 2Q−1 extremes of every operand, both parities of the inverse sum, and the worst-case multiplier input near 4Q. A reset asserted while operands are in flight covers the flush behaviour.

// File: rtl/ntt_bfly_pkg.sv
`timescale 1ns/1ps
package ntt_bfly_pkg;

  // Fixed pipeline geometry: one input register, six multiplier stages,
  // one output register.
  localparam int MUL_STAGES = 6;
  localparam int PIPE_DEPTH = MUL_STAGES + 2;

  // Strobes from the control pipeline to the datapath.
  typedef struct packed {
    logic                  ldIn;    // capture operands
    logic [MUL_STAGES-1:0] ldMul;   // advance multiplier stage k+1
    logic                  ldOut;   // capture final results
    logic                  selInv;  // mode of the pair in the input register
    logic                  outInv;  // mode of the pair entering the output register
  } bflyStrobe_t;

  // -q^-1 mod 2^bits by Newton iteration in 64-bit arithmetic (q odd).
  function automatic logic [63:0] negInvPow2(input logic [63:0] q, input int bits);
    logic [63:0] inv;
    logic [63:0] mask;
    inv = 64'd1;
    for (int i = 0; i < 6; i++) begin
      inv = inv * (64'd2 - q * inv);
    end
    mask = (bits >= 64) ? '1 : ((64'd1 << bits) - 64'd1);
    return (~inv + 64'd1) & mask;
  endfunction

endpackage

// File: rtl/ntt_bfly_ctrl.sv
`timescale 1ns/1ps
module ntt_bfly_ctrl
  import ntt_bfly_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inInverse,
  output bflyStrobe_t strobe,
  output logic        outValid
);

  // Bit k describes the pair held in pipeline register k.
  logic [PIPE_DEPTH-1:0] validPipe;
  logic [PIPE_DEPTH-1:0] modePipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
      modePipe  <= '0;
    end else begin
      validPipe <= {validPipe[PIPE_DEPTH-2:0], inValid};
      modePipe  <= {modePipe[PIPE_DEPTH-2:0], inInverse};
    end
  end

  always_comb begin
    strobe.ldIn   = inValid;
    strobe.ldMul  = validPipe[MUL_STAGES-1:0];
    strobe.ldOut  = validPipe[MUL_STAGES];
    strobe.selInv = modePipe[0];
    strobe.outInv = modePipe[MUL_STAGES];
  end

  assign outValid = validPipe[PIPE_DEPTH-1];

endmodule

// File: rtl/ntt_bfly_mont.sv
`timescale 1ns/1ps
module ntt_bfly_mont
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned W = 17,
  parameter int unsigned Q = 114689
) (
  input  logic                  clk,
  input  logic [MUL_STAGES-1:0] ld,
  input  logic [W+1:0]          opX,   // up to 4Q
  input  logic [W:0]            opY,   // up to 2Q
  output logic [W:0]            res    // below 2Q, no correction
);

  localparam int CW = W + 1;
  localparam int RB = W + 4;           // radix R = 2^RB > 8Q
  localparam int PW = 2 * W + 5;       // holds T + m*Q
  localparam logic [RB-1:0] NEG_QINV = RB'(negInvPow2(64'(Q), RB));
  localparam logic [PW-1:0] Q_P      = PW'(Q);

  logic [PW-1:0] tProd, tP2, tP3, mq;
  logic [RB-1:0] mVal;
  logic [CW-1:0] uHi, rVal;
  logic          lowCarry;

  // T + m*Q is a multiple of R, so its low halves add to 0 or exactly R.
  assign lowCarry = |(tP3[RB-1:0] | mq[RB-1:0]);

  always_ff @(posedge clk) begin
    if (ld[0]) tProd <= PW'(opX) * PW'(opY);
    if (ld[1]) begin
      mVal <= tProd[RB-1:0] * NEG_QINV;
      tP2  <= tProd;
    end
    if (ld[2]) begin
      mq  <= PW'(mVal) * Q_P;
      tP3 <= tP2;
    end
    if (ld[3]) uHi  <= tP3[PW-1:RB] + mq[PW-1:RB] + CW'(lowCarry);
    if (ld[4]) rVal <= uHi;
    if (ld[5]) res  <= rVal;
  end

endmodule

// File: rtl/ntt_bfly_dp.sv
`timescale 1ns/1ps
module ntt_bfly_dp
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned W = 17,
  parameter int unsigned Q = 114689
) (
  input  logic        clk,
  input  bflyStrobe_t strobe,
  input  logic [W:0]  inA,
  input  logic [W:0]  inB,
  input  logic [W:0]  inTw,
  output logic [W:0]  outX,
  output logic [W:0]  outY
);

  localparam int CW = W + 1;
  localparam int XW = W + 2;
  localparam logic [XW-1:0] Q_X     = XW'(Q);
  localparam logic [XW-1:0] TWO_Q_X = XW'(2 * Q);

  logic [CW-1:0] aR, bR, wR;

  always_ff @(posedge clk) begin
    if (strobe.ldIn) begin
      aR <= inA;
      bR <= inB;
      wR <= inTw;
    end
  end

  // Entry stage: multiplier operand and the word that rides beside it.
  logic [XW-1:0] diffInv, mulX, sumRaw, sumRed;
  logic [CW-1:0] sumHalf, sideIn;

  always_comb begin
    diffInv = XW'(aR) + TWO_Q_X - XW'(bR);          // (0,4Q), left uncorrected
    mulX    = strobe.selInv ? diffInv : XW'(bR);
    sumRaw  = XW'(aR) + XW'(bR);
    sumRed  = (sumRaw >= TWO_Q_X) ? sumRaw - TWO_Q_X : sumRaw;
    sumHalf = sumRed[0] ? CW'((sumRed + Q_X) >> 1) : CW'(sumRed >> 1);
    sideIn  = strobe.selInv ? sumHalf : aR;
  end

  logic [CW-1:0] tMul;

  ntt_bfly_mont #(.W(W), .Q(Q)) u_mont (
    .clk (clk),
    .ld  (strobe.ldMul),
    .opX (mulX),
    .opY (wR),
    .res (tMul)
  );

  // Side word delay line, aligned with the multiplier stages.
  logic [MUL_STAGES-1:0][CW-1:0] sideQ, sideSrc;

  generate
    if (MUL_STAGES > 1) begin : g_chain
      assign sideSrc = {sideQ[MUL_STAGES-2:0], sideIn};
    end else begin : g_single
      assign sideSrc = sideIn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int s = 0; s < MUL_STAGES; s++) begin
      if (strobe.ldMul[s]) sideQ[s] <= sideSrc[s];
    end
  end

  // Exit stage: forward add/subtract with one range correction.
  logic [CW-1:0] sideOut, fwdSumC, fwdDifC;
  logic [XW-1:0] fwdSum, fwdDif;

  assign sideOut = sideQ[MUL_STAGES-1];

  always_comb begin
    fwdSum  = XW'(sideOut) + XW'(tMul);
    fwdDif  = XW'(sideOut) + TWO_Q_X - XW'(tMul);
    fwdSumC = CW'((fwdSum >= TWO_Q_X) ? fwdSum - TWO_Q_X : fwdSum);
    fwdDifC = CW'((fwdDif >= TWO_Q_X) ? fwdDif - TWO_Q_X : fwdDif);
  end

  always_ff @(posedge clk) begin
    if (strobe.ldOut) begin
      outX <= strobe.outInv ? sideOut : fwdSumC;
      outY <= strobe.outInv ? tMul    : fwdDifC;
    end
  end

endmodule

// File: rtl/ntt_bfly_unified.sv
`timescale 1ns/1ps
module ntt_bfly_unified
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned W = 17,
  parameter int unsigned Q = 114689
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inInverse,
  input  logic [W:0] inA,
  input  logic [W:0] inB,
  input  logic [W:0] inTwiddle,
  output logic       outValid,
  output logic [W:0] outX,
  output logic [W:0] outY
);

  bflyStrobe_t strobe;

  ntt_bfly_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inInverse (inInverse),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  ntt_bfly_dp #(.W(W), .Q(Q)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .inA    (inA),
    .inB    (inB),
    .inTw   (inTwiddle),
    .outX   (outX),
    .outY   (outY)
  );

endmodule

// File: rtl/ntt_bfly_unified_chk.sv
`timescale 1ns/1ps
module ntt_bfly_unified_chk #(
  parameter int unsigned W = 17,
  parameter int unsigned Q = 114689
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [W:0] inA,
  input logic [W:0] inB,
  input logic [W:0] inTwiddle,
  input logic       outValid,
  input logic [W:0] outX,
  input logic [W:0] outY
);

  localparam int LW = W + 2;
  localparam logic [LW-1:0] TWO_Q = LW'(2 * Q);

  p_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ({1'b0, inA} < TWO_Q && {1'b0, inB} < TWO_Q && {1'b0, inTwiddle} < TWO_Q));

  p_out_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ({1'b0, outX} < TWO_Q && {1'b0, outY} < TWO_Q));

  p_lat_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##8 outValid);

  p_lat_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##8 !outValid);

  p_reset_quiet_r6: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

bind ntt_bfly_unified ntt_bfly_unified_chk #(.W(W), .Q(Q)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inA       (inA),
  .inB       (inB),
  .inTwiddle (inTwiddle),
  .outValid  (outValid),
  .outX      (outX),
  .outY      (outY)
);

// File: tb/ntt_bfly_unified_bench.sv
`timescale 1ns/1ps
module ntt_bfly_unified_bench;

  localparam int W  = 5;
  localparam int Q  = 17;
  localparam int TQ = 2 * Q;
  localparam int RB = W + 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inInverse = 1'b0;
  logic [W:0] inA = '0;
  logic [W:0] inB = '0;
  logic [W:0] inTw = '0;
  logic       outValid;
  logic [W:0] outX, outY;

  ntt_bfly_unified #(.W(W), .Q(Q)) u_ntt_bfly_unified (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inInverse (inInverse),
    .inA       (inA),
    .inB       (inB),
    .inTwiddle (inTw),
    .outValid  (outValid),
    .outX      (outX),
    .outY      (outY)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  int rinv = 0;
  int inv2 = (Q + 1) / 2;
  bit prevMode = 1'b0;

  bit hV [16];
  bit hM [16];
  int hA [16];
  int hB [16];
  int hW [16];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Output seen now belongs to the input driven 8 negedges earlier.
  task automatic checkOutputs();
    int slot, a, b, w, om, ex, ey, s, hx;
    bit expV, m;
    slot = (cyc + 8) & 15;
    expV = (cyc >= 8) ? hV[slot] : 1'b0;
    check(outValid == expV, "R4 valid after 8 cycles", int'(outValid), int'(expV));
    if (expV && outValid) begin
      a = hA[slot]; b = hB[slot]; w = hW[slot]; m = hM[slot];
      om = (w * rinv) % Q;
      check(int'(outX) < TQ, "R3 outX range", int'(outX), TQ - 1);
      check(int'(outY) < TQ, "R3 outY range", int'(outY), TQ - 1);
      if (m) begin
        ex = ((a + b) * inv2) % Q;
        ey = ((((a - b) % Q) + Q) % Q * om) % Q;
        check(int'(outX) % Q == ex, "R2 inverse halved sum", int'(outX) % Q, ex);
        check(int'(outY) % Q == ey, "R2 inverse scaled difference", int'(outY) % Q, ey);
        s = a + b;
        if (s >= TQ) s = s - TQ;
        hx = (s % 2 == 1) ? (s + Q) / 2 : s / 2;
        check(int'(outX) == hx, "R7 exact halving", int'(outX), hx);
      end else begin
        ex = (a + b * om) % Q;
        ey = (((a - b * om) % Q) + Q) % Q;
        check(int'(outX) % Q == ex, "R1 forward sum", int'(outX) % Q, ex);
        check(int'(outY) % Q == ey, "R1 forward difference", int'(outY) % Q, ey);
      end
      if (m != prevMode)
        check((int'(outX) % Q == ex) && (int'(outY) % Q == ey), "R5 mode switch result",
              int'(outX) % Q, ex);
      prevMode = m;
    end
  endtask

  task automatic step(input bit v, input bit m, input int a, input int b, input int w);
    @(negedge clk);
    checkOutputs();
    rstN = 1'b1;
    inValid = v;
    inInverse = m;
    inA = a[W:0];
    inB = b[W:0];
    inTw = w[W:0];
    hV[cyc & 15] = v;
    hM[cyc & 15] = m;
    hA[cyc & 15] = a;
    hB[cyc & 15] = b;
    hW[cyc & 15] = w;
    cyc++;
  endtask

  task automatic doReset(input int n);
    repeat (n) begin
      @(negedge clk);
      rstN = 1'b0;
      inValid = 1'b0;
      #1;
      check(outValid == 1'b0, "R6 outValid low in reset", int'(outValid), 0);
      for (int k = 0; k < 16; k++) hV[k] = 1'b0;
      cyc++;
    end
  endtask

  initial begin
    int cnt;
    for (int r = 1; r < Q; r++)
      if ((((1 << RB) % Q) * r) % Q == 1) rinv = r;

    doReset(4);

    // Exhaustive sweep, mode alternating every cycle (R1, R2, R3, R5, R7).
    cnt = 0;
    for (int a = 0; a < TQ; a++)
      for (int b = 0; b < TQ; b++)
        for (int w = 0; w < TQ; w++)
          for (int m = 0; m < 2; m++) begin
            if (cnt % 101 == 100) step(1'b0, 1'b0, 0, 0, 0);
            step(1'b1, m[0], a, b, w);
            cnt++;
          end
    repeat (10) step(1'b0, 1'b0, 0, 0, 0);

    // Reset with pairs in flight: none may emerge (R6).
    for (int k = 0; k < 5; k++) step(1'b1, k[0], TQ - 1, k, TQ - 1);
    doReset(2);
    repeat (12) step(1'b0, 1'b0, 0, 0, 0);

    // Back-to-back maximal operands after reset (R3, R4).
    for (int k = 0; k < 4; k++) step(1'b1, k[0], TQ - 1, TQ - 1, TQ - 1);
    repeat (10) step(1'b0, 1'b0, 0, 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule